// File: doc/BRIEF.md
# Rank-Routed Network Interface Switch

This block attaches one processing node to a message network of peer nodes. The node side has one outgoing and one incoming 32-bit valid/ready stream. The network side has `N_CH` pairs of unidirectional channels, one pair for each peer interface. Channel `k` leads to peer interface `k`, so channel numbering must follow the node numbering of the network.

Outgoing messages are steered by logical rank rather than by port number. The first word of a message is a header. The destination rank in that header is looked up in a routing table, and the whole message goes out on the channel the table returns. A message with an unmapped destination is drained and discarded, and a sticky error flag is raised.

On the receive side, the node names the source rank it wants to hear from. The table translates that rank to one incoming channel. Exactly one message is then forwarded from that channel, and every other channel is held off. A control node can rewrite the table at run time to redirect paths. A rewrite never disturbs a message already in flight.

Top module: `nis_switch`

## Requirements
- R1: After reset, no network transmit channel is valid, no network receive channel is ready, the node receive stream is not valid, the error flag is low, and the routing table is empty, so every source-rank request is refused.
- R2: The routing table holds two words per rank, with the highest rank at the lowest address. Address `2*(15-r)` is the transmit word of rank `r` and address `2*(15-r)+1` is its receive word. In a written word, bit 2 is the valid bit and bits 1:0 are the channel number.
- R3: A header word carries the payload length in bits 7:0, the destination rank in bits 11:8 and the source rank in bits 15:12. The header and its payload leave, with their data unchanged, on the channel mapped to the destination rank.
- R4: A message holds its channel for the header plus exactly `length` payload words, whatever those payload words contain. A length of 0 means a header-only message. The largest length is 255.
- R5: At most one network transmit channel is valid at any time, and only while the node offers a word of a routed message.
- R6: A receive request is accepted only when the requested source rank is mapped. The block then forwards one header plus `length` payload words from the mapped channel, with the data unchanged, and the node valid follows that channel's valid.
- R7: While a receive message is active, only the selected incoming channel sees ready, and it sees the node's ready. When no receive message is active, no incoming channel sees ready.
- R8: A table write made during a message does not redirect the rest of that message. It takes effect from the next message.
- R9: A message to an unmapped destination is taken from the node without stalls, with its header and all `length` payload words consumed. No channel shows valid for it. The error flag sets and stays set until reset.
- R10: For a routed word, the node transmit ready equals the ready of the selected network channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Routing table write strobe |
| cfg_addr_i | input | 5 | Routing table word address |
| cfg_wdata_i | input | 3 | Table word: bit 2 valid, bits 1:0 channel |
| node_tx_valid_i | input | 1 | Node outgoing word valid |
| node_tx_ready_o | output | 1 | Node outgoing word accepted |
| node_tx_data_i | input | 32 | Node outgoing word |
| node_rx_valid_o | output | 1 | Node incoming word valid |
| node_rx_ready_i | input | 1 | Node ready for incoming word |
| node_rx_data_o | output | 32 | Node incoming word |
| rx_req_valid_i | input | 1 | Request to receive one message from a rank |
| rx_req_ready_o | output | 1 | Receive request accepted |
| rx_req_rank_i | input | 4 | Source rank requested |
| net_tx_valid_o | output | 4 | Per-channel outgoing valid |
| net_tx_ready_i | input | 4 | Per-channel outgoing ready |
| net_tx_data_o | output | 128 | Per-channel outgoing data, channel k at bits 32k+31:32k |
| net_rx_valid_i | input | 4 | Per-channel incoming valid |
| net_rx_ready_o | output | 4 | Per-channel incoming ready |
| net_rx_data_i | input | 128 | Per-channel incoming data, channel k at bits 32k+31:32k |
| route_err_o | output | 1 | Sticky unmapped-destination flag |

## Verification
Outgoing traffic uses random destinations, random lengths from 0 to 5 and random per-channel back-pressure. Unmapped destinations are mixed in, which separates routed messages from drained ones. Payload words carry random bits in the destination field, so a design that looked up the route again on every word would be caught. Directed cases cover the first and last table addresses, a 255-word message, and a table rewrite in the middle of a message. On the receive side, every channel offers random words at the same time. This shows whether only the mapped channel is forwarded and back-pressured, and whether requests for unmapped ranks are refused.

// File: rtl/nis_pkg.sv
package nis_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_DROP} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_HDR, RX_PAY} rx_state_e;
endpackage

// File: rtl/nis_route_table.sv
module nis_route_table #(
  parameter int N_CH   = 4,
  parameter int RANK_W = 4,
  parameter int CH_W   = $clog2(N_CH),
  parameter int AW     = RANK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CH_W:0]     wdata_i,
  input  logic [RANK_W-1:0] tx_rank_i,
  output logic              tx_vld_o,
  output logic [CH_W-1:0]   tx_ch_o,
  input  logic [RANK_W-1:0] rx_rank_i,
  output logic              rx_vld_o,
  output logic [CH_W-1:0]   rx_ch_o
);
  localparam int WORDS = 2 << RANK_W;

  logic [CH_W:0] ent_q [WORDS];
  logic [CH_W:0] tx_ent, rx_ent;
  logic [AW-1:0] tx_idx, rx_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[addr_i] <= wdata_i;
    end
  end

  // highest rank at lowest address: index = 2*(max-rank) + word
  assign tx_idx = {~tx_rank_i, 1'b0};
  assign rx_idx = {~rx_rank_i, 1'b1};
  assign tx_ent = ent_q[tx_idx];
  assign rx_ent = ent_q[rx_idx];

  assign tx_ch_o  = tx_ent[CH_W-1:0];
  assign rx_ch_o  = rx_ent[CH_W-1:0];
  assign tx_vld_o = tx_ent[CH_W] && (int'(tx_ent[CH_W-1:0]) < N_CH);
  assign rx_vld_o = rx_ent[CH_W] && (int'(rx_ent[CH_W-1:0]) < N_CH);
endmodule

// File: rtl/nis_tx_mux.sv
module nis_tx_mux
  import nis_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int RANK_W = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   node_valid_i,
  output logic                   node_ready_o,
  input  logic [DATA_W-1:0]      node_data_i,
  output logic [N_CH-1:0]        net_valid_o,
  input  logic [N_CH-1:0]        net_ready_i,
  output logic [N_CH*DATA_W-1:0] net_data_o,
  output logic [RANK_W-1:0]      lookup_rank_o,
  input  logic                   map_vld_i,
  input  logic [CH_W-1:0]        map_ch_i,
  output logic                   err_o,
  output logic                   active_o,
  output logic [CH_W-1:0]        ch_o
);
  tx_state_e        state_q;
  logic [LEN_W-1:0] rem_q;
  logic [CH_W-1:0]  ch_q;
  logic             err_q;
  logic             fwd;
  logic [CH_W-1:0]  sel;
  logic             fire;
  logic [LEN_W-1:0] hdr_len;

  assign hdr_len       = node_data_i[LEN_W-1:0];
  assign lookup_rank_o = node_data_i[LEN_W +: RANK_W];

  always_comb begin
    fwd = 1'b0;
    sel = ch_q;
    unique case (state_q)
      TX_IDLE: begin fwd = map_vld_i; sel = map_ch_i; end
      TX_SEND: fwd = 1'b1;
      default: fwd = 1'b0;
    endcase
  end

  assign node_ready_o = fwd ? net_ready_i[sel] : 1'b1;
  assign fire         = node_valid_i && node_ready_o;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign net_valid_o[k]                  = node_valid_i && fwd && (sel == CH_W'(k));
    assign net_data_o[k*DATA_W +: DATA_W]  = node_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      rem_q   <= '0;
      ch_q    <= '0;
      err_q   <= 1'b0;
    end else if (fire) begin
      unique case (state_q)
        TX_IDLE: begin
          ch_q <= map_ch_i;
          if (!map_vld_i) err_q <= 1'b1;
          if (hdr_len != '0) begin
            rem_q   <= hdr_len;
            state_q <= map_vld_i ? TX_SEND : TX_DROP;
          end
        end
        default: begin
          rem_q <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) state_q <= TX_IDLE;
        end
      endcase
    end
  end

  assign err_o    = err_q;
  assign active_o = (state_q != TX_IDLE);
  assign ch_o     = ch_q;
endmodule

// File: rtl/nis_rx_demux.sv
module nis_rx_demux
  import nis_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   map_vld_i,
  input  logic [CH_W-1:0]        map_ch_i,
  input  logic [N_CH-1:0]        net_valid_i,
  output logic [N_CH-1:0]        net_ready_o,
  input  logic [N_CH*DATA_W-1:0] net_data_i,
  output logic                   node_valid_o,
  input  logic                   node_ready_i,
  output logic [DATA_W-1:0]      node_data_o,
  output logic                   active_o,
  output logic [CH_W-1:0]        ch_o
);
  rx_state_e        state_q;
  logic [LEN_W-1:0] rem_q;
  logic [CH_W-1:0]  ch_q;
  logic [DATA_W-1:0] ch_data [N_CH];
  logic             busy, fire;

  assign busy = (state_q != RX_IDLE);

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign ch_data[k]     = net_data_i[k*DATA_W +: DATA_W];
    assign net_ready_o[k] = busy && (ch_q == CH_W'(k)) && node_ready_i;
  end

  assign req_ready_o  = !busy && map_vld_i;
  assign node_valid_o = busy && net_valid_i[ch_q];
  assign node_data_o  = ch_data[ch_q];
  assign fire         = node_valid_o && node_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      rem_q   <= '0;
      ch_q    <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: if (req_valid_i && req_ready_o) begin
          ch_q    <= map_ch_i;
          state_q <= RX_HDR;
        end
        RX_HDR: if (fire) begin
          rem_q   <= node_data_o[LEN_W-1:0];
          state_q <= (node_data_o[LEN_W-1:0] == '0) ? RX_IDLE : RX_PAY;
        end
        default: if (fire) begin
          rem_q <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) state_q <= RX_IDLE;
        end
      endcase
    end
  end

  assign active_o = busy;
  assign ch_o     = ch_q;
endmodule

// File: rtl/nis_switch.sv
module nis_switch #(
  parameter int N_CH   = 4,
  parameter int RANK_W = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = $clog2(N_CH),
  parameter int AW     = RANK_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [AW-1:0]          cfg_addr_i,
  input  logic [CH_W:0]          cfg_wdata_i,
  input  logic                   node_tx_valid_i,
  output logic                   node_tx_ready_o,
  input  logic [DATA_W-1:0]      node_tx_data_i,
  output logic                   node_rx_valid_o,
  input  logic                   node_rx_ready_i,
  output logic [DATA_W-1:0]      node_rx_data_o,
  input  logic                   rx_req_valid_i,
  output logic                   rx_req_ready_o,
  input  logic [RANK_W-1:0]      rx_req_rank_i,
  output logic [N_CH-1:0]        net_tx_valid_o,
  input  logic [N_CH-1:0]        net_tx_ready_i,
  output logic [N_CH*DATA_W-1:0] net_tx_data_o,
  input  logic [N_CH-1:0]        net_rx_valid_i,
  output logic [N_CH-1:0]        net_rx_ready_o,
  input  logic [N_CH*DATA_W-1:0] net_rx_data_i,
  output logic                   route_err_o
);
  logic [RANK_W-1:0] tx_rank;
  logic              tx_map_vld, rx_map_vld;
  logic [CH_W-1:0]   tx_map_ch, rx_map_ch;
  logic              tx_active, rx_active;
  logic [CH_W-1:0]   tx_ch, rx_ch;

  nis_route_table #(.N_CH(N_CH), .RANK_W(RANK_W), .CH_W(CH_W), .AW(AW)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .tx_rank_i (tx_rank),
    .tx_vld_o  (tx_map_vld),
    .tx_ch_o   (tx_map_ch),
    .rx_rank_i (rx_req_rank_i),
    .rx_vld_o  (rx_map_vld),
    .rx_ch_o   (rx_map_ch)
  );

  nis_tx_mux #(.N_CH(N_CH), .RANK_W(RANK_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .CH_W(CH_W)) u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .node_valid_i  (node_tx_valid_i),
    .node_ready_o  (node_tx_ready_o),
    .node_data_i   (node_tx_data_i),
    .net_valid_o   (net_tx_valid_o),
    .net_ready_i   (net_tx_ready_i),
    .net_data_o    (net_tx_data_o),
    .lookup_rank_o (tx_rank),
    .map_vld_i     (tx_map_vld),
    .map_ch_i      (tx_map_ch),
    .err_o         (route_err_o),
    .active_o      (tx_active),
    .ch_o          (tx_ch)
  );

  nis_rx_demux #(.N_CH(N_CH), .LEN_W(LEN_W), .DATA_W(DATA_W), .CH_W(CH_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (rx_req_valid_i),
    .req_ready_o  (rx_req_ready_o),
    .map_vld_i    (rx_map_vld),
    .map_ch_i     (rx_map_ch),
    .net_valid_i  (net_rx_valid_i),
    .net_ready_o  (net_rx_ready_o),
    .net_data_i   (net_rx_data_i),
    .node_valid_o (node_rx_valid_o),
    .node_ready_i (node_rx_ready_i),
    .node_data_o  (node_rx_data_o),
    .active_o     (rx_active),
    .ch_o         (rx_ch)
  );
endmodule

// File: rtl/nis_switch_chk.sv
module nis_switch_chk #(
  parameter int N_CH = 4,
  parameter int CH_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] net_tx_valid_i,
  input logic [N_CH-1:0] net_rx_ready_i,
  input logic            route_err_i,
  input logic            tx_active_i,
  input logic [CH_W-1:0] tx_ch_i,
  input logic            rx_active_i,
  input logic [CH_W-1:0] rx_ch_i
);
  a_r5_tx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(net_tx_valid_i));

  a_r7_rx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(net_rx_ready_i));

  a_r7_rx_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_active_i |-> (net_rx_ready_i == '0));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_err_i |=> route_err_i);

  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_i && $past(tx_active_i)) |-> $stable(tx_ch_i));

  a_r6_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_active_i && $past(rx_active_i)) |-> $stable(rx_ch_i));
endmodule

bind nis_switch nis_switch_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .net_tx_valid_i (net_tx_valid_o),
  .net_rx_ready_i (net_rx_ready_o),
  .route_err_i    (route_err_o),
  .tx_active_i    (tx_active),
  .tx_ch_i        (tx_ch),
  .rx_active_i    (rx_active),
  .rx_ch_i        (rx_ch)
);

// File: tb/tb_nis_switch.sv
module tb_nis_switch;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_ni;
  logic cfg_we_i;
  logic [4:0] cfg_addr_i;
  logic [2:0] cfg_wdata_i;
  logic node_tx_valid_i, node_tx_ready_o;
  logic [DW-1:0] node_tx_data_i;
  logic node_rx_valid_o, node_rx_ready_i;
  logic [DW-1:0] node_rx_data_o;
  logic rx_req_valid_i, rx_req_ready_o;
  logic [3:0] rx_req_rank_i;
  logic [NC-1:0] net_tx_valid_o, net_tx_ready_i;
  logic [NC*DW-1:0] net_tx_data_o;
  logic [NC-1:0] net_rx_valid_i, net_rx_ready_o;
  logic [NC*DW-1:0] net_rx_data_i;
  logic route_err_o;

  int checks = 0;
  int errors = 0;
  int tx_map [NR];
  int rx_map [NR];

  always #5 clk = ~clk;

  nis_switch dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .node_tx_valid_i(node_tx_valid_i), .node_tx_ready_o(node_tx_ready_o), .node_tx_data_i(node_tx_data_i),
    .node_rx_valid_o(node_rx_valid_o), .node_rx_ready_i(node_rx_ready_i), .node_rx_data_o(node_rx_data_o),
    .rx_req_valid_i(rx_req_valid_i), .rx_req_ready_o(rx_req_ready_o), .rx_req_rank_i(rx_req_rank_i),
    .net_tx_valid_o(net_tx_valid_o), .net_tx_ready_i(net_tx_ready_i), .net_tx_data_o(net_tx_data_o),
    .net_rx_valid_i(net_rx_valid_i), .net_rx_ready_o(net_rx_ready_o), .net_rx_data_i(net_rx_data_i),
    .route_err_o(route_err_o)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_write(int addr, bit vld, int ch);
    int rank = NR - 1 - addr / 2;
    if (addr % 2 == 0) tx_map[rank] = vld ? ch : -1;
    else               rx_map[rank] = vld ? ch : -1;
  endfunction

  function automatic logic [DW-1:0] mk_hdr(int src, int dst, int len);
    return {16'h0, 4'(src), 4'(dst), 8'(len)};
  endfunction

  task automatic cfg_write(int addr, bit vld, int ch);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 5'(addr); cfg_wdata_i = {vld, 2'(ch)};
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
    model_write(addr, vld, ch);
  endtask

  // rw_word >= 0 issues a table write while that word is offered
  task automatic send_msg(int dst, int len, int rw_word = -1, int rw_addr = 0, int rw_ch = 0);
    int exp_ch = tx_map[dst];
    for (int w = 0; w <= len; w++) begin
      logic [DW-1:0] d = (w == 0) ? mk_hdr(9, dst, len) : $urandom;
      int guard = 0;
      bit done = 0;
      while (!done) begin
        logic [NC-1:0] exp_v;
        logic exp_r;
        @(negedge clk);
        node_tx_valid_i = 1'b1;
        node_tx_data_i  = d;
        net_tx_ready_i  = (guard > 2) ? '1 : NC'($urandom);
        if (w == rw_word) begin
          cfg_we_i = 1'b1; cfg_addr_i = 5'(rw_addr); cfg_wdata_i = {1'b1, 2'(rw_ch)};
        end
        #1;
        exp_v = (exp_ch < 0) ? '0 : NC'(1 << exp_ch);
        exp_r = (exp_ch < 0) ? 1'b1 : net_tx_ready_i[exp_ch];
        chk(exp_ch < 0 ? "R9" : "R5", "net_tx_valid", 64'(net_tx_valid_o), 64'(exp_v));
        chk(exp_ch < 0 ? "R9" : "R10", "node_tx_ready", 64'(node_tx_ready_o), 64'(exp_r));
        if (exp_ch >= 0) chk("R3", "net_tx_data", 64'(net_tx_data_o[exp_ch*DW +: DW]), 64'(d));
        done = exp_r;
        guard++;
        @(posedge clk); #1;
        cfg_we_i = 1'b0;
      end
    end
    if (rw_word >= 0 && rw_word <= len) model_write(rw_addr, 1'b1, rw_ch);
    @(negedge clk);
    node_tx_valid_i = 1'b0;
    net_tx_ready_i  = '1;
  endtask

  task automatic recv_msg(int src, int len);
    int exp_ch = rx_map[src];
    @(negedge clk);
    rx_req_valid_i = 1'b1;
    rx_req_rank_i  = 4'(src);
    #1;
    chk("R6", "rx_req_ready", 64'(rx_req_ready_o), 64'(exp_ch >= 0));
    @(posedge clk); #1;
    rx_req_valid_i = 1'b0;
    if (exp_ch < 0) begin
      @(negedge clk);
      net_rx_valid_i = '1;
      node_rx_ready_i = 1'b1;
      #1;
      chk("R6", "refused request opens no channel", 64'(net_rx_ready_o), 64'(0));
      chk("R6", "refused request node valid", 64'(node_rx_valid_o), 64'(0));
      net_rx_valid_i = '0;
      return;
    end
    for (int w = 0; w <= len; w++) begin
      logic [DW-1:0] d = (w == 0) ? mk_hdr(src, 2, len) : $urandom;
      int guard = 0;
      bit done = 0;
      while (!done) begin
        bit sel_v;
        @(negedge clk);
        sel_v = (guard > 2) ? 1'b1 : 1'($urandom);
        for (int k = 0; k < NC; k++) begin
          net_rx_valid_i[k]          = (k == exp_ch) ? sel_v : 1'($urandom);
          net_rx_data_i[k*DW +: DW]  = (k == exp_ch) ? d : $urandom;
        end
        node_rx_ready_i = (guard > 2) ? 1'b1 : 1'($urandom);
        #1;
        chk("R6", "node_rx_valid", 64'(node_rx_valid_o), 64'(sel_v));
        chk("R6", "node_rx_data", 64'(node_rx_data_o), 64'(d));
        chk("R7", "net_rx_ready", 64'(net_rx_ready_o),
            64'(node_rx_ready_i ? (1 << exp_ch) : 0));
        done = sel_v && node_rx_ready_i;
        guard++;
        @(posedge clk);
      end
    end
    @(negedge clk);
    net_rx_valid_i  = '1;
    node_rx_ready_i = 1'b1;
    #1;
    chk("R7", "idle after message", 64'(net_rx_ready_o), 64'(0));
    net_rx_valid_i = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int r = 0; r < NR; r++) begin tx_map[r] = -1; rx_map[r] = -1; end
    rst_ni = 1'b0;
    cfg_we_i = 0; cfg_addr_i = '0; cfg_wdata_i = '0;
    node_tx_valid_i = 0; node_tx_data_i = '0;
    node_rx_ready_i = 0; rx_req_valid_i = 0; rx_req_rank_i = '0;
    net_tx_ready_i = '1; net_rx_valid_i = '0; net_rx_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "net_tx_valid", 64'(net_tx_valid_o), 64'(0));
    chk("R1", "net_rx_ready", 64'(net_rx_ready_o), 64'(0));
    chk("R1", "node_rx_valid", 64'(node_rx_valid_o), 64'(0));
    chk("R1", "route_err", 64'(route_err_o), 64'(0));
    chk("R1", "rx_req_ready", 64'(rx_req_ready_o), 64'(0));

    // R9 empty table: message drained, error sets
    send_msg(5, 3);
    #1 chk("R9", "route_err set", 64'(route_err_o), 64'(1));

    // R2 boundary addresses: rank 15 at address 0, rank 0 at address 31
    cfg_write(0, 1'b1, 1);
    cfg_write(30, 1'b1, 3);
    cfg_write(31, 1'b1, 2);
    send_msg(15, 2);
    send_msg(0, 0);
    recv_msg(0, 2);

    for (int r = 1; r < NR - 1; r++) begin
      if (r % 5 != 4) begin
        cfg_write(2 * (NR - 1 - r), 1'b1, int'($urandom % NC));
        cfg_write(2 * (NR - 1 - r) + 1, 1'b1, int'($urandom % NC));
      end
    end

    // R3 R4 R5 R10 random traffic including unmapped destinations
    for (int i = 0; i < 40; i++) send_msg(int'($urandom % NR), int'($urandom % 6));

    // R4 longest message
    send_msg(0, 255);

    // R8 rewrite of rank 3 mid-message keeps channel 0, next message uses 2
    cfg_write(24, 1'b1, 0);
    send_msg(3, 4, 1, 24, 2);
    send_msg(3, 1);

    // R9 error remains after clean traffic
    #1 chk("R9", "route_err sticky", 64'(route_err_o), 64'(1));

    // R6 R7 receive side, including unmapped rank 4
    recv_msg(4, 1);
    for (int i = 0; i < 20; i++) recv_msg(int'($urandom % NR), int'($urandom % 5));

    summary();
    $finish;
  end
endmodule